// File: doc/BRIEF.md
# Quad-Input Flash Page Program Target

This block is the target-side command front end of a serial flash device for the page program operation, where the data arrives four bits per clock. It runs on a fast system clock and oversamples chip select, the serial clock and four data lines. It decodes a one-byte instruction sent one bit per clock. It then takes a 24-bit address, either one bit per clock or four bits per clock depending on the instruction. After that it collects data bytes as nibble pairs into a 256-byte page buffer.

When chip select is released exactly on a byte boundary, the operation is accepted if the write enable latch was set and the page is not protected. A fixed-length program cycle then starts. A write-enable instruction arms the latch. A suspend instruction freezes the cycle countdown and a resume instruction releases it. When the countdown ends, the whole page buffer is offered to the array in one cycle, together with a per-byte mask of the bytes that were received.

Top module: `qpp_target`

## Requirements
- R1: After reset, `wip`, `wel` and `arr_we` are 0.
- R2: A write-enable instruction (0x06, eight bits on `dq[0]`, most significant bit first, then chip select high with no further clock) sets `wel` when no cycle is running.
- R3: Instruction 0x32 takes the 24-bit address on `dq[0]`, most significant bit first, over 24 clocks. Instruction 0x38 takes it over 6 clocks, four bits per clock on `dq[3:0]`, most significant nibble first. `arr_page` carries address bits 23..8.
- R4: Each data byte takes two clocks, high nibble first: `dq[3:0]` carries bits 7..4 on the first clock and bits 3..0 on the second.
- R5: The first data byte goes to the in-page offset given by address bits 7..0. Each later byte goes to the next offset, wrapping from 255 to 0. Only received offsets are set in `arr_wmask`. Byte k is on `arr_wdata[8k+7:8k]`.
- R6: When more than 256 bytes are sent, each offset holds the last byte written to it.
- R7: If chip select rises when no data byte has been received, or partway through a byte, no cycle starts and `wel` is unchanged.
- R8: An accepted operation raises `wip` on the first clock edge that sees chip select high. `wip` stays high for exactly PROG_CYCLES unsuspended clock cycles. On the edge where `wip` falls, `arr_we` pulses high for one cycle.
- R9: `wel` is cleared when the program cycle starts.
- R10: With protect level `bp` = n and n > 0, the protected region is the top (`tb`=0) or bottom (`tb`=1) min(2^(n-1), 256) sectors of 64 KB, where the sector is address bits 23..16. Programming a protected sector starts no cycle and leaves `wel` unchanged.
- R11: A program instruction sent while `wel` is 0 starts no cycle.
- R12: A suspend instruction (0x75) sent while `wip` is high stops the countdown. `wip` stays high while suspended. A resume instruction (0x7A) continues the countdown from where it stopped.
- R13: A write-enable instruction sent while `wip` is high leaves `wel` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| dq | input | 4 | Data lines; instruction and narrow address use bit 0 only |
| bp | input | 4 | Block protect level |
| tb | input | 1 | Protect region side: 0 top, 1 bottom |
| wip | output | 1 | Write in progress |
| wel | output | 1 | Write enable latch |
| arr_we | output | 1 | One-cycle array write strobe |
| arr_page | output | 16 | Page number for the array write |
| arr_wdata | output | 2048 | Page buffer contents, byte k at bits 8k+7..8k |
| arr_wmask | output | 256 | Per-byte valid mask |

## Verification
The bench sends bursts that start near the top of a page so that the offset must wrap. A design that stops at the page end would lose the tail bytes, and one that carries into the next page would report the wrong page. A 300-byte burst checks that later bytes overwrite earlier ones and that the mask stays full. The bench also raises chip select after half a byte and after no data at all; a design that counts only whole clocks or never checks for data would start a cycle it should drop. Suspend and resume, protected sectors at both sides of a region edge, and write-enable sent while busy are compared clock by clock against a behavioural model. These cases catch a timer that keeps counting while suspended, an off-by-one in the region decode, and a latch that re-arms during a cycle.

// File: rtl/qpp_target.sv
module qpp_target #(
  parameter int PROG_CYCLES = 1000,
  parameter logic [7:0] OP_WREN = 8'h06,
  parameter logic [7:0] OP_PROG = 8'h32,
  parameter logic [7:0] OP_PROG_X = 8'h38,
  parameter logic [7:0] OP_SUSP = 8'h75,
  parameter logic [7:0] OP_RES = 8'h7A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic [3:0]    dq,
  input  logic [3:0]    bp,
  input  logic          tb,
  output logic          wip,
  output logic          wel,
  output logic          arr_we,
  output logic [15:0]   arr_page,
  output logic [2047:0] arr_wdata,
  output logic [255:0]  arr_wmask
);
  localparam int TW = $clog2(PROG_CYCLES + 1);
  typedef enum logic [2:0] {S_CMD, S_ADR, S_DAT, S_END, S_IGN} st_t;

  st_t st;
  logic cs_p, sclk_p, ext, nib, anyb, susp;
  logic [7:0] opc, off;
  logic [4:0] cnt;
  logic [23:0] adr;
  logic [3:0] hi;
  logic [TW-1:0] tmr;
  logic [7:0] pbuf [256];
  logic [255:0] mask;

  wire cs_rise = cs_n & ~cs_p;
  wire edge_s = sclk & ~sclk_p & ~cs_n;
  wire [7:0] opc_n = {opc[6:0], dq[0]};
  wire [23:0] adr_n = ext ? {adr[19:0], dq} : {adr[22:0], dq[0]};
  wire adr_last = ext ? (cnt == 5'd5) : (cnt == 5'd23);
  wire [8:0] nsec = (bp == 4'd0) ? 9'd0 : (bp >= 4'd9) ? 9'd256 : (9'd1 << (bp - 4'd1));
  wire [8:0] sec = {1'b0, adr[23:16]};
  wire prot = tb ? (sec < nsec) : (sec + nsec >= 9'd256);
  wire go = cs_rise && st == S_DAT && !nib && anyb && !prot;

  assign arr_page = adr[23:8];
  assign arr_wmask = mask;
  for (genvar g = 0; g < 256; g++) begin : g_out
    assign arr_wdata[8*g +: 8] = pbuf[g];
  end

  always_ff @(posedge clk)
    if (edge_s && st == S_DAT && nib) pbuf[off] <= {hi, dq};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_p <= 1'b1; sclk_p <= 1'b0; st <= S_CMD; cnt <= '0; opc <= '0; adr <= '0;
      ext <= 1'b0; nib <= 1'b0; anyb <= 1'b0; hi <= '0; off <= '0; mask <= '0;
      wip <= 1'b0; wel <= 1'b0; susp <= 1'b0; tmr <= '0; arr_we <= 1'b0;
    end else begin
      cs_p <= cs_n;
      sclk_p <= sclk;
      arr_we <= 1'b0;
      if (wip && !susp) begin
        if (tmr == '0) begin
          wip <= 1'b0;
          arr_we <= 1'b1;
        end else tmr <= tmr - 1'b1;
      end
      if (cs_n) begin
        st <= S_CMD;
        cnt <= '0;
      end else if (edge_s) begin
        case (st)
          S_CMD: begin
            opc <= opc_n;
            cnt <= cnt + 5'd1;
            if (cnt == 5'd7) begin
              cnt <= '0;
              if (opc_n == OP_PROG || opc_n == OP_PROG_X) begin
                st <= (wel && !wip) ? S_ADR : S_IGN;
                ext <= (opc_n == OP_PROG_X);
              end else st <= S_END;
            end
          end
          S_ADR: begin
            adr <= adr_n;
            cnt <= cnt + 5'd1;
            if (adr_last) begin
              st <= S_DAT; nib <= 1'b0; anyb <= 1'b0; mask <= '0; off <= adr_n[7:0];
            end
          end
          S_DAT:
            if (!nib) begin
              hi <= dq;
              nib <= 1'b1;
            end else begin
              mask[off] <= 1'b1;
              off <= off + 8'd1;
              nib <= 1'b0;
              anyb <= 1'b1;
            end
          default: st <= S_IGN;
        endcase
      end
      if (go) begin
        wip <= 1'b1;
        wel <= 1'b0;
        tmr <= TW'(PROG_CYCLES - 1);
      end
      if (cs_rise && st == S_END)
        case (opc)
          OP_WREN: if (!wip) wel <= 1'b1;
          OP_SUSP: if (wip) susp <= 1'b1;
          OP_RES:  susp <= 1'b0;
          default: ;
        endcase
    end

  assert_we_ends_wip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (!wip && $past(wip)));
  assert_start_clears_wel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> !wel);
  assert_start_on_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> ($past(st) == S_DAT && !$past(nib) && $past(cs_n)));
  assert_hold_when_suspended_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && susp) |=> (wip && $stable(tmr)));
  assert_mask_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (arr_wmask != '0));
  assert_wel_idle_only_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(wip));
endmodule

// File: tb/qpp_target_test.sv
module qpp_target_test;
  localparam int P = 400;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, tb = 1'b0;
  logic [3:0] dq = '0, bp = '0;
  logic wip, wel, arr_we;
  logic [15:0] arr_page;
  logic [2047:0] arr_wdata;
  logic [255:0] arr_wmask;

  qpp_target #(.PROG_CYCLES(P)) uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .dq(dq), .bp(bp), .tb(tb), .wip(wip), .wel(wel), .arr_we(arr_we),
    .arr_page(arr_page), .arr_wdata(arr_wdata), .arr_wmask(arr_wmask));

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, pend = 0, m_left = 0;
  bit m_wip = 0, m_wel = 0, m_susp = 0, m_we = 0, w0, done = 0;
  logic [2047:0] exp_data = '0;
  logic [255:0] exp_mask = '0;
  logic [15:0] exp_page = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_prot(input int lvl, input int bot, input int s);
    int n;
    n = (lvl == 0) ? 0 : (lvl >= 9) ? 256 : (1 << (lvl - 1));
    return bot ? (s < n) : (s >= 256 - n);
  endfunction

  // behavioural reference: countdown first with old state, then the pending event
  always @(posedge clk) begin
    w0 = m_wip;
    m_we = 0;
    if (m_wip && !m_susp) begin
      if (m_left == 0) begin m_wip = 0; m_we = 1; end
      else m_left--;
    end
    case (pend)
      1: begin m_wip = 1; m_left = P - 1; m_wel = 0; end
      2: if (!w0) m_wel = 1;
      3: if (w0) m_susp = 1;
      4: m_susp = 0;
      default: ;
    endcase
    pend = 0;
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(wip === m_wip, "R8 wip", wip, m_wip);
    chk(wel === m_wel, "R2 R9 wel", wel, m_wel);
    chk(arr_we === m_we, "R8 arr_we", arr_we, m_we);
    if (arr_we && m_we) begin
      chk(arr_page == exp_page, "R3 page", arr_page, exp_page);
      chk(arr_wmask == exp_mask, "R5 mask count", $countones(arr_wmask), $countones(exp_mask));
      for (int i = 0; i < 256; i++)
        if (exp_mask[i]) chk(arr_wdata[8*i +: 8] == exp_data[8*i +: 8], "R4 R6 data",
                             arr_wdata[8*i +: 8], exp_data[8*i +: 8]);
    end
  end

  task automatic half(); repeat (2) @(negedge clk); endtask
  task automatic clk_out(input logic [3:0] v);
    dq = v; sclk = 0; half(); sclk = 1; half(); sclk = 0;
  endtask
  task automatic begin_tx(); cs_n = 0; half(); endtask
  task automatic end_tx(input int ev);
    sclk = 0; half(); cs_n = 1; pend = ev; half(); half();
  endtask
  task automatic send_b1(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) clk_out({3'b000, b[i]});
  endtask
  task automatic cmd(input logic [7:0] op, input int ev);
    begin_tx(); send_b1(op); end_tx(ev);
  endtask
  task automatic wait_idle(); while (wip) @(negedge clk); half(); endtask

  task automatic prog(input bit ext, input logic [23:0] a, input int n, input int seed, input bit cut);
    bit acc;
    acc = m_wel && !m_wip && n > 0 && !cut && !is_prot(int'(bp), int'(tb), int'(a[23:16]));
    if (acc) begin
      exp_mask = '0;
      exp_page = a[23:8];
      for (int i = 0; i < n; i++) begin
        exp_data[8*((int'(a[7:0]) + i) % 256) +: 8] = 8'((i * seed + 3) % 256);
        exp_mask[(int'(a[7:0]) + i) % 256] = 1'b1;
      end
    end
    begin_tx();
    send_b1(ext ? 8'h38 : 8'h32);
    if (ext) for (int k = 5; k >= 0; k--) clk_out(a[4*k +: 4]);
    else for (int k = 23; k >= 0; k--) clk_out({3'b000, a[k]});
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'((i * seed + 3) % 256);
      clk_out(b[7:4]);
      clk_out(b[3:0]);
    end
    if (cut) clk_out(4'h5);
    end_tx(acc ? 1 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(wip == 0 && wel == 0 && arr_we == 0, "R1 reset outputs", {wip, wel, arr_we}, 0);
    rst_n = 1;
    half();
    prog(0, 24'h012345, 3, 5, 0);
    chk(wip == 0, "R11 program without wel", wip, 0);
    cmd(8'h06, 2);
    chk(wel == 1, "R2 write enable", wel, 1);
    prog(0, 24'h012345, 3, 9, 0);
    chk(wip == 1 && wel == 0, "R9 cycle start", {wip, wel}, 2'b10);
    wait_idle();
    cmd(8'h06, 2);
    prog(1, 24'h0A00FE, 4, 5, 0);
    chk(wip == 1, "R3 wide address accepted", wip, 1);
    wait_idle();
    cmd(8'h06, 2);
    prog(0, 24'h123410, 300, 7, 0);
    chk(wip == 1, "R6 long burst accepted", wip, 1);
    wait_idle();
    cmd(8'h06, 2);
    prog(0, 24'h000000, 2, 3, 1);
    chk(wip == 0 && wel == 1, "R7 half byte dropped", {wip, wel}, 2'b01);
    prog(1, 24'h000000, 0, 3, 0);
    chk(wip == 0 && wel == 1, "R7 no data dropped", {wip, wel}, 2'b01);
    bp = 4'd1; tb = 0;
    prog(0, 24'hFF0000, 2, 3, 0);
    chk(wip == 0 && wel == 1, "R10 top sector protected", {wip, wel}, 2'b01);
    bp = 4'd2; tb = 1;
    prog(0, 24'h01FF00, 2, 3, 0);
    chk(wip == 0 && wel == 1, "R10 bottom sector protected", {wip, wel}, 2'b01);
    prog(1, 24'h0200F0, 2, 11, 0);
    chk(wip == 1, "R10 sector past region accepted", wip, 1);
    wait_idle();
    bp = 4'd0; tb = 0;
    cmd(8'h06, 2);
    prog(0, 24'h7777C0, 3, 13, 0);
    repeat (100) @(negedge clk);
    cmd(8'h75, 3);
    repeat (500) @(negedge clk);
    chk(wip == 1, "R12 suspended cycle held", wip, 1);
    cmd(8'h06, 2);
    chk(wel == 0, "R13 write enable while busy", wel, 0);
    cmd(8'h7A, 4);
    wait_idle();
    chk(wip == 0, "R12 resumed cycle finished", wip, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule